// File: doc/BRIEF.md
# Debug Event Qualification Unit

This block sits after the debug comparators of a processor pipeline and decides, once per retiring instruction, which comparison hits become recorded debug events. It takes hits from two instruction-address comparators (channels 1 and 3) and two data-address comparators (channels 1 and 2). It also takes a trap-condition-met strobe and a taken-branch strobe. These are qualified against per-event enables, link controls and two mode bits. Qualified events are kept in sticky status bits that software clears by writing ones. A separate set of one-cycle pulses goes to a debug counter.

A data comparator can be linked to an instruction comparator: data channel 1 to instruction channel 1, and data channel 2 to instruction channel 3. Data channel 2 can be linked only when it is not being used as a mask or range bound. A linked data event needs both hits from the same instruction. A linked instruction hit never reaches status, but the counter still sees it. A multi-word load or store cut short by an interrupt suppresses linked data events. On a taken-branch event for which the debug interrupt is taken, the branch's address is saved.

Top module: `dbg_evt_qual`

## Requirements
- R1: Inputs are evaluated only in cycles with `retire_vld` high. Status bits and `save_addr` change on the next clock edge. `cnt_evt` is high for exactly the cycle after such an evaluation and is zero in the cycle after any cycle with `retire_vld` low.
- R2: Status and counter bit positions are: 0 = instruction channel 1, 1 = instruction channel 3, 2 = data channel 1, 3 = data channel 2, 4 = trap, 5 = taken branch. An unlinked comparator hit whose enable is set sets its status bit.
- R3: Link 1 is active when `lnk_da1` is set. Link 2 is active when `lnk_da2` is set and `da2_mask` is clear. With a link active, the data status bit is set only when the data hit, the partner instruction hit and the data enable are all present in the same evaluation.
- R4: With a link active, the partner instruction status bit (bit 0 for link 1, bit 1 for link 2) is never set by an evaluation. This holds whatever its hit or enable.
- R5: A linked data event is neither recorded nor pulsed when `mw_intr` is high in its evaluation. Data events are recorded independently of `dbg_mode`.
- R6: Each `cnt_evt` bit pulses for its event without regard to the enable inputs. Instruction hits pulse even when linked. Linked data bits follow the link rule of R3 and R5.
- R7: A trap event (`trap_met` with `en_trap`) sets status bit 4 regardless of `dbg_mode`.
- R8: A taken-branch event requires `br_taken`, `en_br`, and `dbg_mode` or `ext_dbg`. With both mode bits clear it sets neither status bit 5 nor `cnt_evt[5]`.
- R9: `save_addr` loads `insn_addr` only when a taken-branch status event is evaluated with `int_taken` high. Otherwise it holds.
- R10: Status bits are sticky. A one on `clr_w1c` clears the bit on the next edge, and a set arriving in the same cycle wins over the clear.
- R11: Reset (`rst_n` low) forces status, `cnt_evt` and `save_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_vld | input | 1 | Retiring instruction; evaluate inputs this cycle |
| ia1_hit | input | 1 | Instruction comparator channel 1 hit |
| ia3_hit | input | 1 | Instruction comparator channel 3 hit |
| da1_hit | input | 1 | Data comparator channel 1 hit |
| da2_hit | input | 1 | Data comparator channel 2 hit |
| trap_met | input | 1 | Trap instruction with condition met |
| br_taken | input | 1 | Branch that will be taken |
| en_ia1 | input | 1 | Enable instruction channel 1 event |
| en_ia3 | input | 1 | Enable instruction channel 3 event |
| en_da1 | input | 1 | Enable data channel 1 event |
| en_da2 | input | 1 | Enable data channel 2 event |
| en_trap | input | 1 | Enable trap event |
| en_br | input | 1 | Enable taken-branch event |
| lnk_da1 | input | 1 | Link data channel 1 to instruction channel 1 |
| lnk_da2 | input | 1 | Link data channel 2 to instruction channel 3 |
| da2_mask | input | 1 | Data channel 2 used as mask or range bound |
| dbg_mode | input | 1 | Debug-enable mode bit |
| ext_dbg | input | 1 | External debug mode bit |
| mw_intr | input | 1 | Multi-word load/store interrupted before completion |
| int_taken | input | 1 | Debug interrupt taken for this instruction |
| insn_addr | input | AW | Address of the retiring instruction |
| clr_w1c | input | 6 | Write-one-to-clear mask for status |
| status | output | 6 | Sticky event status |
| cnt_evt | output | 6 | One-cycle event pulses for the debug counter |
| save_addr | output | AW | Saved taken-branch instruction address |

## Verification
The assertions assume that every input holds a defined 0 or 1 across each rising edge. They also assume that hit, enable and mode inputs mean something only in cycles where `retire_vld` is high. The stimulus changes all inputs only on falling edges and draws every one as a clean bit, so no input is ever undefined at an edge. Hits, links, mode bits and clears are biased so that linked, unlinked, suppressed and masked cases all occur often. `int_taken` is asserted freely, including in cycles with no branch event, which exercises the hold side of the address capture.

// File: rtl/dbg_evt_qual.sv
module dbg_evt_qual #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_vld,
  input  logic          ia1_hit,
  input  logic          ia3_hit,
  input  logic          da1_hit,
  input  logic          da2_hit,
  input  logic          trap_met,
  input  logic          br_taken,
  input  logic          en_ia1,
  input  logic          en_ia3,
  input  logic          en_da1,
  input  logic          en_da2,
  input  logic          en_trap,
  input  logic          en_br,
  input  logic          lnk_da1,
  input  logic          lnk_da2,
  input  logic          da2_mask,
  input  logic          dbg_mode,
  input  logic          ext_dbg,
  input  logic          mw_intr,
  input  logic          int_taken,
  input  logic [AW-1:0] insn_addr,
  input  logic [5:0]    clr_w1c,
  output logic [5:0]    status,
  output logic [5:0]    cnt_evt,
  output logic [AW-1:0] save_addr
);

  logic       lk1, lk2, brt_ok;
  logic [5:0] raw, ena, set_v;

  assign lk1    = lnk_da1;
  assign lk2    = lnk_da2 & ~da2_mask;
  assign brt_ok = br_taken & (dbg_mode | ext_dbg);

  assign raw = {brt_ok,
                trap_met,
                lk2 ? (da2_hit & ia3_hit & ~mw_intr) : da2_hit,
                lk1 ? (da1_hit & ia1_hit & ~mw_intr) : da1_hit,
                ia3_hit,
                ia1_hit};

  assign ena = {en_br, en_trap, en_da2, en_da1, en_ia3 & ~lk2, en_ia1 & ~lk1};

  assign set_v = retire_vld ? (raw & ena) : 6'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= '0;
      cnt_evt   <= '0;
      save_addr <= '0;
    end else begin
      status  <= (status & ~clr_w1c) | set_v;
      cnt_evt <= retire_vld ? raw : 6'b0;
      if (set_v[5] && int_taken)
        save_addr <= insn_addr;
    end
  end

  // R1
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_vld |=> cnt_evt == 6'b0);

  // R4
  ia1_link_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && lnk_da1 && !status[0]) |=> !status[0]);

  // R4
  ia3_link_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && lnk_da2 && !da2_mask && !status[1]) |=> !status[1]);

  // R5
  mw_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && lnk_da1 && mw_intr) |=> !cnt_evt[2]);

  // R6
  ia_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && ia1_hit) |=> cnt_evt[0]);

  // R7
  trap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && trap_met && en_trap) |=> status[4]);

  // R8
  brt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && !dbg_mode && !ext_dbg && !status[5]) |=> (!status[5] && !cnt_evt[5]));

  // R9
  save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_vld && int_taken) |=> $stable(save_addr));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_vld |=> status == ($past(status) & ~$past(clr_w1c)));

endmodule

// File: tb/dbg_evt_qual_bench.sv
module dbg_evt_qual_bench;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic retire_vld = 0, ia1_hit = 0, ia3_hit = 0, da1_hit = 0, da2_hit = 0;
  logic trap_met = 0, br_taken = 0, en_ia1 = 0, en_ia3 = 0, en_da1 = 0, en_da2 = 0;
  logic en_trap = 0, en_br = 0, lnk_da1 = 0, lnk_da2 = 0, da2_mask = 0;
  logic dbg_mode = 0, ext_dbg = 0, mw_intr = 0, int_taken = 0;
  logic [AW-1:0] insn_addr = '0;
  logic [5:0] clr_w1c = '0;
  logic [5:0] status, cnt_evt;
  logic [AW-1:0] save_addr;

  int tests = 0, fails = 0;
  logic [5:0] m_status = '0, m_cnt = '0;
  logic [AW-1:0] m_save = '0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_evt_qual #(.AW(AW)) u_dbg_evt_qual (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld),
    .ia1_hit(ia1_hit), .ia3_hit(ia3_hit), .da1_hit(da1_hit), .da2_hit(da2_hit),
    .trap_met(trap_met), .br_taken(br_taken),
    .en_ia1(en_ia1), .en_ia3(en_ia3), .en_da1(en_da1), .en_da2(en_da2),
    .en_trap(en_trap), .en_br(en_br), .lnk_da1(lnk_da1), .lnk_da2(lnk_da2),
    .da2_mask(da2_mask), .dbg_mode(dbg_mode), .ext_dbg(ext_dbg),
    .mw_intr(mw_intr), .int_taken(int_taken), .insn_addr(insn_addr),
    .clr_w1c(clr_w1c), .status(status), .cnt_evt(cnt_evt), .save_addr(save_addr));

  // Behavioural reference: R1 timing, outputs follow the edge after evaluation
  always @(posedge clk) begin
    if (rst_n) begin
      logic [5:0] s, c;
      bit link1, link2, brt;
      s = '0; c = '0;
      link1 = lnk_da1;
      link2 = lnk_da2 && !da2_mask;
      brt = br_taken && (dbg_mode || ext_dbg);
      if (retire_vld) begin
        // R2 R4 R6: instruction hits count always, record only unlinked
        if (ia1_hit) begin c[0] = 1; if (en_ia1 && !link1) s[0] = 1; end
        if (ia3_hit) begin c[1] = 1; if (en_ia3 && !link2) s[1] = 1; end
        // R3 R5: linked data events need partner hit and no interrupted multi-word access
        if (link1) begin
          if (da1_hit && ia1_hit && !mw_intr) begin c[2] = 1; if (en_da1) s[2] = 1; end
        end else if (da1_hit) begin c[2] = 1; if (en_da1) s[2] = 1; end
        if (link2) begin
          if (da2_hit && ia3_hit && !mw_intr) begin c[3] = 1; if (en_da2) s[3] = 1; end
        end else if (da2_hit) begin c[3] = 1; if (en_da2) s[3] = 1; end
        // R7
        if (trap_met) begin c[4] = 1; if (en_trap) s[4] = 1; end
        // R8
        if (brt) begin c[5] = 1; if (en_br) s[5] = 1; end
        // R9
        if (brt && en_br && int_taken) m_save <= insn_addr;
      end
      // R10: clear then set, set wins
      m_status <= (m_status & ~clr_w1c) | s;
      m_cnt <= c;
    end
  end

  function automatic string bit_req(int b);
    case (b)
      0, 1: return "R2 R4 R10";
      2, 3: return "R3 R5 R10";
      4: return "R7 R10";
      default: return "R8 R10";
    endcase
  endfunction

  task automatic compare_all();
    for (int b = 0; b < 6; b++) begin
      tests++;
      if (status[b] !== m_status[b]) begin
        fails++;
        $display("FAIL %s status[%0d] actual=%b expected=%b", bit_req(b), b, status[b], m_status[b]);
      end
    end
    tests++;
    if (cnt_evt !== m_cnt) begin
      fails++;
      $display("FAIL R6 R1 cnt_evt actual=%b expected=%b", cnt_evt, m_cnt);
    end
    tests++;
    if (save_addr !== m_save) begin
      fails++;
      $display("FAIL R9 save_addr actual=%h expected=%h", save_addr, m_save);
    end
  endtask

  task automatic drive_random();
    retire_vld = ($urandom_range(0, 3) != 0);
    ia1_hit  = $urandom_range(0, 1);  ia3_hit = $urandom_range(0, 1);
    da1_hit  = $urandom_range(0, 1);  da2_hit = $urandom_range(0, 1);
    trap_met = ($urandom_range(0, 3) == 0);
    br_taken = ($urandom_range(0, 2) == 0);
    en_ia1 = $urandom_range(0, 1); en_ia3 = $urandom_range(0, 1);
    en_da1 = $urandom_range(0, 1); en_da2 = $urandom_range(0, 1);
    en_trap = $urandom_range(0, 1); en_br = $urandom_range(0, 1);
    lnk_da1 = $urandom_range(0, 1); lnk_da2 = $urandom_range(0, 1);
    da2_mask = ($urandom_range(0, 3) == 0);
    dbg_mode = $urandom_range(0, 1); ext_dbg = ($urandom_range(0, 3) == 0);
    mw_intr = ($urandom_range(0, 3) == 0);
    int_taken = $urandom_range(0, 1);
    insn_addr = $urandom();
    clr_w1c = ($urandom_range(0, 2) == 0) ? 6'($urandom()) : 6'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    tests++;
    if (status !== 6'b0 || cnt_evt !== 6'b0 || save_addr !== '0) begin
      fails++;
      $display("FAIL R11 reset actual=%b/%b/%h expected=0/0/0", status, cnt_evt, save_addr);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compare_all();
      drive_random();
    end
    @(negedge clk);
    compare_all();
    finish_run();
  end
endmodule